// File: doc/BRIEF.md
# Framed SPI Host Transmitter

This block is the transmit side of an SPI host that frames every character with a frame-sync output. It accepts 8-bit characters on a ready/valid stream and serialises them on SCK and MOSI. All serial timing is paced by a baud tick input. One baud tick is half an SCK period. SCK idles low, data goes out MSB first, and MOSI changes only on falling SCK edges. Each character forms one frame, and each frame gets its own frame-sync assertion.

The frame sync can be set to either polarity. It can be a two-tick strobe or a level that lasts the whole frame. Its active edge can come one bit clock before the first rising SCK edge, or at that edge. Between characters, a 6-bit spacing value adds idle baud ticks during which SCK cannot toggle.

While `run` is high, a new frame is due as soon as the previous one and its spacing have ended. If no character is waiting when a frame is due, an underrun flag is raised and an all-zero frame is sent. The flag stays set until `urun_clr` is pulsed. While the flag is set, a policy bit chooses between two behaviours: keep sending zero frames and hold back waiting characters, or send waiting characters anyway.

Top module: `framed_spi_host_tx`

## Requirements
- R1: After reset, SCK and MOSI are low, FSYNC sits at its inactive level, and `underrun` and `busy` are low.
- R2: A frame holds 16 baud ticks of shifting. During the odd half-periods SCK is high. Bits go out MSB first. MOSI changes only while SCK is low, and SCK is low outside frames.
- R3: With `cfg_fs_pol`=0 FSYNC is active high. With `cfg_fs_pol`=1 it is active low, and its inactive level equals `cfg_fs_pol`.
- R4: With `cfg_fs_level`=0, FSYNC is active for exactly two baud ticks (one SCK period) per frame.
- R5: With `cfg_fs_level`=1, FSYNC stays active from its first edge until the last bit's half-period ends.
- R6: With `cfg_fs_coincide`=0, a lead tick precedes the first bit and FSYNC becomes active two ticks before SCK first rises. With `cfg_fs_coincide`=1 it becomes active on the tick SCK first rises.
- R7: A non-zero `cfg_gap` holds SCK low and `busy` high for `cfg_gap` extra baud ticks after the last bit of a character before the next frame may start.
- R8: With `cfg_gap`=0 and `run` high, the next frame starts on the tick that ends the previous one.
- R9: A frame that is due while `in_valid` is low sets `underrun` and sends zeros. The flag stays set until a `urun_clr` pulse, and a new underrun on the same cycle wins over the clear.
- R10: With `cfg_ign_underrun`=0 and `underrun` set, frames carry zeros and no character is accepted.
- R11: With `cfg_ign_underrun`=1, a waiting character is sent even while `underrun` is set.
- R12: `in_ready` is high only on the baud tick that starts a frame, and at most one character is accepted per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Half-SCK-period pacing strobe |
| run | input | 1 | Frames are issued while high |
| cfg_fs_pol | input | 1 | FSYNC polarity, 1 = active low |
| cfg_fs_level | input | 1 | 0 = two-tick strobe, 1 = frame-long level |
| cfg_fs_coincide | input | 1 | 0 = FSYNC leads first SCK rise, 1 = coincides |
| cfg_ign_underrun | input | 1 | 1 = send waiting data despite underrun |
| cfg_gap | input | 6 | Extra SCK-quiet baud ticks between characters |
| urun_clr | input | 1 | Clears the underrun flag |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character is waiting |
| in_ready | output | 1 | Character accepted this cycle when valid |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync |
| underrun | output | 1 | Sticky underrun flag |
| busy | output | 1 | Frame or spacing in progress |

## Verification
The bench drives stream patterns that separate the two underrun policies. In one pattern characters arrive on time. In another the stream runs dry, so zero frames are sent and the flag is set. In a third, characters arrive while the flag is still set: this is the only pattern in which the policy bit changes what goes out on the wire, zeros or data. These patterns are run across all three frame-sync axes and across baud tick rates of one, two and three clocks. The longest SCK-low run inside a busy period is measured separately. That measurement tells back-to-back frames apart from spaced ones, a lead tick from a coincident start, and the smallest spacing from the largest.

// File: rtl/framed_spi_host_tx.sv
module framed_spi_host_tx #(
  parameter int CHAR_W = 8,
  parameter int GAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              run,
  input  logic              cfg_fs_pol,
  input  logic              cfg_fs_level,
  input  logic              cfg_fs_coincide,
  input  logic              cfg_ign_underrun,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              urun_clr,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              sck,
  output logic              mosi,
  output logic              fsync,
  output logic              underrun,
  output logic              busy
);

  localparam int PH_W = $clog2(2 * CHAR_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * CHAR_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP} st_t;

  st_t               state;
  logic [PH_W-1:0]   ph;
  logic [GAP_W-1:0]  gcnt;
  logic [CHAR_W-1:0] shreg;
  logic              uflag;
  logic              fs_act;

  wire at_end = (state == S_SHIFT) && (ph == PH_LAST);
  wire slot   = baud_tick && run &&
                ((state == S_IDLE) || (state == S_GAP && gcnt == GAP_W'(1)) ||
                 (at_end && cfg_gap == '0));
  wire take   = in_ready && in_valid;

  assign in_ready = slot && (cfg_ign_underrun || !uflag);
  assign sck      = (state == S_SHIFT) && ph[0];
  assign mosi     = (state == S_SHIFT || state == S_LEAD) && shreg[CHAR_W-1];
  assign fsync    = fs_act ^ cfg_fs_pol;
  assign underrun = uflag;
  assign busy     = (state != S_IDLE);

  always_comb begin
    fs_act = 1'b0;
    if (state == S_LEAD)
      fs_act = 1'b1;
    else if (state == S_SHIFT) begin
      if (cfg_fs_coincide)
        fs_act = cfg_fs_level ? (ph != '0) : (ph == PH_W'(1) || ph == PH_W'(2));
      else
        fs_act = cfg_fs_level ? 1'b1 : (ph == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ph    <= '0;
      gcnt  <= '0;
      shreg <= '0;
      uflag <= 1'b0;
    end else begin
      if (slot && !in_valid)
        uflag <= 1'b1;
      else if (urun_clr)
        uflag <= 1'b0;

      if (baud_tick) begin
        if (slot) begin
          shreg <= take ? in_data : '0;
          ph    <= '0;
          state <= cfg_fs_coincide ? S_SHIFT : S_LEAD;
        end else begin
          case (state)
            S_LEAD: state <= S_SHIFT;
            S_SHIFT: begin
              if (ph == PH_LAST) begin
                if (cfg_gap != '0) begin
                  state <= S_GAP;
                  gcnt  <= cfg_gap;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                ph <= ph + PH_W'(1);
                if (ph[0])
                  shreg <= {shreg[CHAR_W-2:0], 1'b0};
              end
            end
            S_GAP: begin
              if (gcnt == GAP_W'(1))
                state <= S_IDLE;
              else
                gcnt <= gcnt - GAP_W'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !mosi && fsync == cfg_fs_pol));

  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r5_level_covers_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fs_level && sck) |-> (fsync != cfg_fs_pol));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !urun_clr) |=> underrun);

  a_r12_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !(in_ready && in_valid));

endmodule

// File: tb/tb_framed_spi_host_tx.sv
`timescale 1ns/100ps
module tb_framed_spi_host_tx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, pol = 1'b0, lvl = 1'b0, coin = 1'b0, ign = 1'b0;
  logic [5:0] gap = '0;
  logic clr = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, sck_o, mosi_o, fs_o, ur_o, busy_o;

  framed_spi_host_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .run(run),
    .cfg_fs_pol(pol), .cfg_fs_level(lvl), .cfg_fs_coincide(coin),
    .cfg_ign_underrun(ign), .cfg_gap(gap), .urun_clr(clr),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sck(sck_o), .mosi(mosi_o), .fsync(fs_o), .underrun(ur_o), .busy(busy_o)
  );

  int checks = 0, errors = 0;
  int tdiv = 3, tcnt = 0, cyc = 0;
  int taken = 0;
  logic [7:0] q[$];
  bit finished = 0;

  int mpos = -2, mg = 0;
  logic [7:0] mb = '0;
  bit mflag = 0;

  int low_run = 0, maxq = 0;
  bit seen_high = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_slot();
    return run && (mpos == -2 || (mpos == 16 && mg == 1) || (mpos == 15 && gap == 0));
  endfunction

  function automatic bit e_sck();
    return (mpos >= 0 && mpos <= 15 && (mpos % 2) == 1);
  endfunction

  function automatic bit e_mosi();
    if (mpos < -1 || mpos > 15) return 1'b0;
    return mb[7 - ((mpos < 0) ? 0 : mpos / 2)];
  endfunction

  function automatic bit e_fs();
    int s;
    bit act;
    s = coin ? 1 : -1;
    act = lvl ? (mpos >= s && mpos <= 15) : (mpos == s || mpos == s + 1);
    return act ^ pol;
  endfunction

  // reference model
  always @(posedge clk) begin
    bit slot, rdy;
    slot = 0;
    rdy = 0;
    cyc++;
    if (rst_n) begin
      if (tick) begin
        slot = is_slot();
        rdy = slot && (ign || !mflag);
        if (slot) begin
          if (!in_valid) mflag = 1;
          mb = (rdy && in_valid) ? in_data : 8'h00;
          if (rdy && in_valid) begin
            void'(q.pop_front());
            taken++;
          end
          mpos = coin ? 0 : -1;
        end else if (mpos == -1) mpos = 0;
        else if (mpos >= 0 && mpos < 15) mpos++;
        else if (mpos == 15) begin
          if (gap != 0) begin mpos = 16; mg = gap; end
          else mpos = -2;
        end else if (mpos == 16) begin
          if (mg == 1) mpos = -2; else mg--;
        end
      end
      if (clr && !(slot && !in_valid)) mflag = 0;
    end
  end

  // drive and compare every cycle
  always @(negedge clk) begin
    tcnt++;
    tick <= ((tcnt % tdiv) == 0);
    in_valid <= (q.size() > 0);
    in_data <= (q.size() > 0) ? q[0] : 8'h00;
    #1;
    if (rst_n) begin
      chk(sck_o == e_sck(), "R2 sck", sck_o, e_sck());
      chk(mosi_o == e_mosi(), "R2 mosi", mosi_o, e_mosi());
      chk(fs_o == e_fs(), "R3 R4 R5 R6 fsync", fs_o, e_fs());
      chk(ur_o == mflag, "R9 underrun", ur_o, mflag);
      chk(busy_o == (mpos != -2), "R7 R8 busy", busy_o, mpos != -2);
      chk(in_ready == (tick && is_slot() && (ign || !mflag)), "R12 in_ready",
          in_ready, tick && is_slot() && (ign || !mflag));
      if (!busy_o) begin seen_high = 0; low_run = 0; end
      else if (sck_o) begin
        if (seen_high && low_run > maxq) maxq = low_run;
        seen_high = 1;
        low_run = 0;
      end else low_run++;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_idle();
    @(negedge clk);
    run = 0;
    while (busy_o || mpos != -2) @(negedge clk);
    cycles(2);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    cycles(1);
  endtask

  task automatic wait_taken(input int n);
    while (taken < n) @(negedge clk);
  endtask

  initial begin
    cycles(4);
    chk(sck_o == 0 && mosi_o == 0, "R1 reset serial", {sck_o, mosi_o}, 0);
    chk(fs_o == pol, "R1 reset fsync", fs_o, pol);
    chk(ur_o == 0 && busy_o == 0, "R1 reset flags", {ur_o, busy_o}, 0);
    @(negedge clk); rst_n = 1;
    cycles(3);

    // strobe, lead edge, no gap, live data policy; then run dry
    tdiv = 3; pol = 0; lvl = 0; coin = 0; gap = 0; ign = 1;
    q.push_back(8'hA5); q.push_back(8'h3C); q.push_back(8'h81); q.push_back(8'h5A);
    @(negedge clk); run = 1;
    wait_taken(4);
    cycles(150);
    chk(ur_o == 1, "R9 flag after dry stream", ur_o, 1);
    to_idle();
    chk(taken == 4, "R12 one char per frame", taken, 4);
    cycles(20);
    chk(ur_o == 1, "R9 flag sticky", ur_o, 1);
    pulse_clr();
    chk(ur_o == 0, "R9 flag cleared", ur_o, 0);

    // level, coincide, back-to-back, active low
    tdiv = 2; pol = 1; lvl = 1; coin = 1; gap = 0;
    maxq = 0;
    q.push_back(8'hF0); q.push_back(8'h0F); q.push_back(8'h96);
    @(negedge clk); run = 1;
    wait_taken(7);
    to_idle();
    chk(maxq == 2, "R8 back-to-back quiet", maxq, 2);
    chk(ur_o == 0, "R9 no underrun when fed", ur_o, 0);

    // zero-fill policy with held data, gap 5, lead edge
    tdiv = 3; pol = 0; lvl = 1; coin = 0; gap = 5; ign = 0;
    maxq = 0;
    @(negedge clk); run = 1;
    cycles(120);
    q.push_back(8'hC3); q.push_back(8'h7E);
    cycles(200);
    chk(taken == 7, "R10 data held while flagged", taken, 7);
    chk(q.size() == 2, "R10 queue untouched", q.size(), 2);
    pulse_clr();
    wait_taken(9);
    to_idle();
    chk(maxq == 21, "R7 gap 5 quiet with lead", maxq, 21);
    pulse_clr();

    // live-data policy while flagged
    tdiv = 2; pol = 1; lvl = 0; coin = 0; gap = 1; ign = 1;
    @(negedge clk); run = 1;
    cycles(100);
    chk(ur_o == 1, "R9 flag set before data", ur_o, 1);
    q.push_back(8'h11); q.push_back(8'hEE);
    wait_taken(11);
    to_idle();
    chk(taken == 11, "R11 data sent while flagged", taken, 11);
    chk(ur_o == 1, "R11 flag kept", ur_o, 1);
    pulse_clr();

    // largest gap, strobe, coincide
    tdiv = 1; pol = 1; lvl = 0; coin = 1; gap = 6'd63; ign = 0;
    maxq = 0;
    q.push_back(8'h42); q.push_back(8'hBD);
    @(negedge clk); run = 1;
    wait_taken(13);
    to_idle();
    chk(maxq == 64, "R7 gap 63 quiet", maxq, 64);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule